// File: doc/BRIEF.md
# ADC Per-Channel Limit Monitor

This block sits behind an ADC conversion sequencer and inspects every finished conversion. For each channel it holds a programmable window, a high threshold and a low threshold, and flags results that fall outside that window. It also tracks the largest and the smallest result a channel has ever produced.

Every result raises a conversion-finished event for its channel. A result outside the window raises an out-of-window event. One global error event reports that a channel produced a new result before software acknowledged the previous one. All events land in a sticky status register. A mask register decides which of them reach the single interrupt line. Software reaches the thresholds, the mask, the status and the history through a simple word-addressed register port. Writes take effect at a clock edge, and read data is combinational from the address.

The register map assumes four channels. Address 0 holds the mask, address 1 the status, addresses 4+ch the level registers and addresses 8+ch the history registers.

Top module: `adc_limit_monitor`

## Requirements
- R1: After reset, every source is masked (mask reads 0x1FFF), status reads 0, and each level register reads 0x03FF0000 (high 0x3FF, low 0). Each history register reads 0x000003FF (maximum 0, minimum 0x3FF), and irq is low.
- R2: A write to address 4+ch loads the high threshold from bits 25:16 and the low threshold from bits 9:0, and a read of that address returns them in the same positions.
- R3: A level write whose low value is not strictly below its high value is ignored, and the register keeps its previous contents.
- R4: Each result strobe sets the conversion-finished status bit ch (bits 3:0).
- R5: A result strictly greater than the channel's high threshold sets the above-window bit 8+ch. A result equal to the high threshold does not set it.
- R6: A result strictly less than the channel's low threshold sets the below-window bit 4+ch. A result equal to the low threshold does not set it.
- R7: Address 8+ch returns the largest result seen in bits 31:16 and the smallest in bits 15:0, zero-extended, and both update with the result strobe.
- R8: Status bits are sticky. Writing address 1 clears exactly the bits written as 1, and bits written as 0 are unchanged.
- R9: In the mask at address 0, a 1 disables a source. irq is high exactly when some status bit is set whose mask bit is 0.
- R10: Status bit 12 (error) is set when a result arrives for a channel whose conversion-finished bit is still set. A result on a channel whose bit is clear does not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_valid | input | 1 | One-cycle strobe for a finished conversion |
| res_ch | input | 2 | Channel of the finished conversion |
| res_value | input | 10 | Conversion result |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 4 | Word address of the register access |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq | output | 1 | Interrupt request |

## Verification
Window comparison is driven with results inside the window, exactly on each threshold, and one step outside each threshold. This separates strict from inclusive comparison and shows which edge a wrong comparator would trip on. History is fed a rising and then a falling sequence on one channel, which shows that the maximum and minimum update independently of each other. Error detection is tried in two ways: consecutive results on different channels, which must not flag, and repeated results on one channel without acknowledgement, which must flag. Masking is exercised with pending events both fully masked and selectively unmasked.

// File: rtl/adcmon_pkg.sv
// Package: shared definitions for the ADC limit monitor.
// Assumes a 32-bit register word and a two-bit region field at the top of
// the word address.
package adcmon_pkg;
    localparam int REG_W = 32;

    typedef enum logic [1:0] {
        RGN_CTRL  = 2'd0,
        RGN_LEVEL = 2'd1,
        RGN_HIST  = 2'd2,
        RGN_NONE  = 2'd3
    } region_e;
endpackage

// File: rtl/adcmon_chan.sv
// Module: one channel's threshold pair, extreme-value history and window
// comparators.
// Assumes hit is high for at most one cycle per result and belongs to this
// channel only.
module adcmon_chan #(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lvl_wr,
    input  logic [DATA_W-1:0] wr_hi,
    input  logic [DATA_W-1:0] wr_lo,
    input  logic              hit,
    input  logic [DATA_W-1:0] value,
    output logic [DATA_W-1:0] lvl_hi,
    output logic [DATA_W-1:0] lvl_lo,
    output logic [DATA_W-1:0] hist_max,
    output logic [DATA_W-1:0] hist_min,
    output logic              ev_below,
    output logic              ev_above
);
    // Threshold register: accept only an ordered pair (low below high).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_hi <= '1;
            lvl_lo <= '0;
        end else if (lvl_wr && (wr_lo < wr_hi)) begin
            lvl_hi <= wr_hi;
            lvl_lo <= wr_lo;
        end
    end

    // Extreme tracking: widen the seen range with each result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_max <= '0;
            hist_min <= '1;
        end else if (hit) begin
            if (value > hist_max) hist_max <= value;
            if (value < hist_min) hist_min <= value;
        end
    end

    // Window comparators: strict on both edges.
    always_comb begin
        ev_below = hit && (value < lvl_lo);
        ev_above = hit && (value > lvl_hi);
    end
endmodule

// File: rtl/adcmon_irq.sv
// Module: sticky status with write-one-to-clear, mask register and
// interrupt reduction.
// Assumes a new event set in the same cycle as a clear of that bit wins.
module adcmon_irq #(
    parameter int SRC_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] set_vec,
    input  logic             mask_wr,
    input  logic             stat_wr,
    input  logic [SRC_W-1:0] wdata,
    output logic [SRC_W-1:0] mask_q,
    output logic [SRC_W-1:0] status_q,
    output logic             irq
);
    // Mask register: every source is disabled out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '1;
        else if (mask_wr) mask_q <= wdata;
    end

    // Status register: hold, clear the bits written as one, then set the new events.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~(stat_wr ? wdata : '0)) | set_vec;
    end

    // Interrupt line: any pending source that is enabled.
    assign irq = |(status_q & ~mask_q);
endmodule

// File: rtl/adc_limit_monitor.sv
// Module: top of the ADC limit monitor. It decodes register accesses,
// routes each result to its channel and assembles the event vector.
// Assumes NUM_CH <= 10, so that 3*NUM_CH+1 sources fit one word, and
// DATA_W <= 16. Register word map: region in the top two address bits
// (0 control, 1 levels, 2 history), channel or control index below.
module adc_limit_monitor
    import adcmon_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 10,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W = CH_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [CH_W-1:0]   res_ch,
    input  logic [DATA_W-1:0] res_value,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq
);
    localparam int SRC_W   = 3 * NUM_CH + 1;
    localparam int ERR_BIT = 3 * NUM_CH;
    localparam int PAD_W   = 16 - DATA_W;

    region_e                       region;
    logic    [CH_W-1:0]            idx;
    logic    [NUM_CH-1:0]          hit;
    logic    [NUM_CH-1:0]          lvl_wr;
    logic    [NUM_CH-1:0]          below;
    logic    [NUM_CH-1:0]          above;
    logic    [NUM_CH-1:0][DATA_W-1:0] lvl_hi;
    logic    [NUM_CH-1:0][DATA_W-1:0] lvl_lo;
    logic    [NUM_CH-1:0][DATA_W-1:0] hmax;
    logic    [NUM_CH-1:0][DATA_W-1:0] hmin;
    logic    [SRC_W-1:0]           set_vec;
    logic    [SRC_W-1:0]           mask_q;
    logic    [SRC_W-1:0]           status_q;
    logic                          mask_wr;
    logic                          stat_wr;

    // Address split: region on top, index below.
    assign region = region_e'(reg_addr[ADDR_W-1 -: 2]);
    assign idx    = reg_addr[CH_W-1:0];

    // Control-register write strobes.
    assign mask_wr = reg_we && (region == RGN_CTRL) && (idx == CH_W'(0));
    assign stat_wr = reg_we && (region == RGN_CTRL) && (idx == CH_W'(1));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        // Per-channel steering of results and level writes.
        assign hit[i]    = res_valid && (res_ch == CH_W'(i));
        assign lvl_wr[i] = reg_we && (region == RGN_LEVEL) && (idx == CH_W'(i));

        adcmon_chan #(.DATA_W(DATA_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .lvl_wr   (lvl_wr[i]),
            .wr_hi    (reg_wdata[16 +: DATA_W]),
            .wr_lo    (reg_wdata[DATA_W-1:0]),
            .hit      (hit[i]),
            .value    (res_value),
            .lvl_hi   (lvl_hi[i]),
            .lvl_lo   (lvl_lo[i]),
            .hist_max (hmax[i]),
            .hist_min (hmin[i]),
            .ev_below (below[i]),
            .ev_above (above[i])
        );
    end

    // Event vector: done, below, above per channel, then the global error.
    always_comb begin
        set_vec                       = '0;
        set_vec[NUM_CH-1:0]           = hit;
        set_vec[2*NUM_CH-1:NUM_CH]    = below;
        set_vec[3*NUM_CH-1:2*NUM_CH]  = above;
        set_vec[ERR_BIT]              = |(hit & status_q[NUM_CH-1:0]);
    end

    adcmon_irq #(.SRC_W(SRC_W)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .mask_wr  (mask_wr),
        .stat_wr  (stat_wr),
        .wdata    (reg_wdata[SRC_W-1:0]),
        .mask_q   (mask_q),
        .status_q (status_q),
        .irq      (irq)
    );

    // Read multiplexer: combinational from the address.
    always_comb begin
        reg_rdata = '0;
        unique case (region)
            RGN_CTRL: begin
                if (idx == CH_W'(0))      reg_rdata = {{(REG_W-SRC_W){1'b0}}, mask_q};
                else if (idx == CH_W'(1)) reg_rdata = {{(REG_W-SRC_W){1'b0}}, status_q};
            end
            RGN_LEVEL: begin
                if (int'(idx) < NUM_CH)
                    reg_rdata = {{PAD_W{1'b0}}, lvl_hi[idx], {PAD_W{1'b0}}, lvl_lo[idx]};
            end
            RGN_HIST: begin
                if (int'(idx) < NUM_CH)
                    reg_rdata = {{PAD_W{1'b0}}, hmax[idx], {PAD_W{1'b0}}, hmin[idx]};
            end
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/adcmon_chk.sv
// Module: property checker for the ADC limit monitor, attached by bind.
// Assumes NUM_CH is a power of two, so every res_ch value names a channel.
module adcmon_chk #(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 10,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int SRC_W = 3 * NUM_CH + 1
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       res_valid,
    input logic [CH_W-1:0]            res_ch,
    input logic [DATA_W-1:0]          res_value,
    input logic                       irq,
    input logic [SRC_W-1:0]           mask_q,
    input logic [SRC_W-1:0]           status_q,
    input logic [NUM_CH-1:0][DATA_W-1:0] lvl_hi,
    input logic [NUM_CH-1:0][DATA_W-1:0] lvl_lo,
    input logic [NUM_CH-1:0][DATA_W-1:0] hmax,
    input logic [NUM_CH-1:0][DATA_W-1:0] hmin
);
    // R4
    done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> status_q[$past(res_ch)]);

    // R5
    above_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && (res_value > lvl_hi[res_ch])) |=> status_q[2*NUM_CH + int'($past(res_ch))]);

    // R6
    below_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && (res_value < lvl_lo[res_ch])) |=> status_q[NUM_CH + int'($past(res_ch))]);

    // R7
    hist_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> ((hmax[$past(res_ch)] >= $past(res_value)) &&
                       (hmin[$past(res_ch)] <= $past(res_value))));

    // R9
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_q) |-> !irq);

    // R10
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && status_q[res_ch]) |=> status_q[3*NUM_CH]);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        // R3
        level_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
            lvl_lo[i] < lvl_hi[i]);

        // R7
        max_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (hmax[i] >= $past(hmax[i])));

        // R7
        min_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (hmin[i] <= $past(hmin[i])));
    end
endmodule

bind adc_limit_monitor adcmon_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .res_valid (res_valid),
    .res_ch    (res_ch),
    .res_value (res_value),
    .irq       (irq),
    .mask_q    (mask_q),
    .status_q  (status_q),
    .lvl_hi    (lvl_hi),
    .lvl_lo    (lvl_lo),
    .hmax      (hmax),
    .hmin      (hmin)
);

// File: tb/tb_adc_limit_monitor.sv
`timescale 1ns/100ps
module tb_adc_limit_monitor;
    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [1:0]  res_ch = '0;
    logic [9:0]  res_value = '0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    adc_limit_monitor dut (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ch(res_ch),
        .res_value(res_value), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    fails  = 0;
    bit    chk_now = 1'b0;
    bit    done = 1'b0;

    // Reference model, built from the requirements
    logic [12:0] m_mask = 13'h1FFF;
    logic [12:0] m_status = '0;
    logic [9:0]  m_hi[NCH];
    logic [9:0]  m_lo[NCH];
    logic [9:0]  m_max[NCH];
    logic [9:0]  m_min[NCH];

    // Monitor: pop the expected item and compare while the data is stable
    always @(negedge clk) begin
        if (chk_now && q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = q.pop_front();
            act = it.is_irq ? {31'b0, irq} : reg_rdata;
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
        if (a == 4'd0) m_mask = d[12:0];
        else if (a == 4'd1) m_status = m_status & ~d[12:0];
        else if (a >= 4'd4 && a <= 4'd7) begin
            if (d[9:0] < d[25:16]) begin
                m_hi[a-4] = d[25:16];
                m_lo[a-4] = d[9:0];
            end
        end
    endtask

    task automatic conv(input int ch, input logic [9:0] v);
        @(posedge clk); #1;
        res_valid = 1'b1; res_ch = 2'(ch); res_value = v;
        @(posedge clk); #1;
        res_valid = 1'b0;
        if (m_status[ch]) m_status[12] = 1'b1;
        m_status[ch] = 1'b1;
        if (v < m_lo[ch]) m_status[NCH+ch] = 1'b1;
        if (v > m_hi[ch]) m_status[2*NCH+ch] = 1'b1;
        if (v > m_max[ch]) m_max[ch] = v;
        if (v < m_min[ch]) m_min[ch] = v;
    endtask

    task automatic expect_item(input bit is_irq, input logic [3:0] a,
                               input logic [31:0] e, input string tag);
        item_t it;
        @(posedge clk); #1;
        reg_addr = a;
        it.is_irq = is_irq; it.exp = e; it.tag = tag;
        q.push_back(it);
        chk_now = 1'b1;
        @(negedge clk); #1;
        chk_now = 1'b0;
    endtask

    task automatic chk_status(input string tag);
        expect_item(1'b0, 4'd1, {19'b0, m_status}, tag);
    endtask

    task automatic chk_level(input int ch, input string tag);
        expect_item(1'b0, 4'(4 + ch), {6'b0, m_hi[ch], 6'b0, m_lo[ch]}, tag);
    endtask

    task automatic chk_hist(input int ch, input string tag);
        expect_item(1'b0, 4'(8 + ch), {6'b0, m_max[ch], 6'b0, m_min[ch]}, tag);
    endtask

    task automatic chk_irq(input string tag);
        expect_item(1'b1, 4'd0, {31'b0, |(m_status & ~m_mask)}, tag);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Driver
    initial begin
        for (int i = 0; i < NCH; i++) begin
            m_hi[i] = 10'h3FF; m_lo[i] = 10'h000;
            m_max[i] = 10'h000; m_min[i] = 10'h3FF;
        end
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        expect_item(1'b0, 4'd0, 32'h0000_1FFF, "R1 mask after reset");
        expect_item(1'b0, 4'd1, 32'h0, "R1 status after reset");
        for (int i = 0; i < NCH; i++) begin
            expect_item(1'b0, 4'(4 + i), 32'h03FF_0000, "R1 level after reset");
            expect_item(1'b0, 4'(8 + i), 32'h0000_03FF, "R1 history after reset");
        end
        chk_irq("R1 irq after reset");

        // R2 level programming
        wr(4'd4, 32'h0200_0100);
        chk_level(0, "R2 level ch0");
        wr(4'd5, 32'h0300_0010);
        chk_level(1, "R2 level ch1");

        // R3 disordered pairs are ignored
        wr(4'd4, 32'h0100_0180);
        chk_level(0, "R3 low above high ignored");
        wr(4'd4, 32'h0200_0200);
        expect_item(1'b0, 4'd4, 32'h0200_0100, "R3 equal pair ignored");

        // R4 / R7 in-window result
        conv(0, 10'h150);
        chk_status("R4 done bit ch0");
        chk_hist(0, "R7 history after first result");
        chk_irq("R9 fully masked keeps irq low");

        // R8 write-one-to-clear
        wr(4'd1, 32'h0);
        chk_status("R8 zero write leaves status");
        wr(4'd1, 32'h1);
        expect_item(1'b0, 4'd1, 32'h0, "R8 clear done bit");

        // R6 low boundary, then below
        conv(0, 10'h100);
        chk_status("R6 equal to low not flagged");
        wr(4'd1, 32'h1FFF);
        conv(0, 10'h0FF);
        chk_status("R6 below low flagged");
        chk_hist(0, "R7 minimum follows falling result");
        wr(4'd1, 32'h1FFF);

        // R5 high boundary, then above
        conv(0, 10'h200);
        chk_status("R5 equal to high not flagged");
        wr(4'd1, 32'h1FFF);
        conv(0, 10'h201);
        chk_status("R5 above high flagged");
        chk_hist(0, "R7 maximum follows rising result");

        // R9 masking
        chk_irq("R9 masked above event");
        wr(4'd0, 32'h1EFF);
        chk_irq("R9 unmasked above event raises irq");
        wr(4'd1, 32'h100);
        chk_irq("R9 only masked bits left");

        // R10 error detection
        wr(4'd1, 32'h1FFF);
        conv(2, 10'h020);
        conv(3, 10'h030);
        chk_status("R10 different channels no error");
        conv(3, 10'h031);
        chk_status("R10 repeat without clear sets error");
        wr(4'd0, 32'h0FFF);
        chk_irq("R9 unmasked error raises irq");
        chk_hist(3, "R7 history ch3");

        @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule